// File: doc/BRIEF.md
# Bridge Error and Event Interrupt Status Unit

This block gathers the error and event conditions of a bus bridge into two sticky status registers and turns them into one interrupt line for the host. Four bus error conditions land in the top nibble of a 16-bit error word. Eight local-side event conditions land in an 8-bit event byte. An 8-bit mask register selects which events may interrupt, and a global enable bit must be set before any event reaches the output.

Detection logic elsewhere raises single-cycle pulses on `err_pulse` and `evt_pulse`. Software reads the registers through a combinational read port selected by `rd_sel`. It writes them through a one-cycle write strobe with a register select and a 16-bit data word. The two status registers clear in different ways. The error word is write-one-to-clear, so writing back the value just read acknowledges exactly the flags that were seen. The event byte is cleared as a whole by writing zero to it.

Register select encoding, shared by `wr_sel` and `rd_sel`: 0 = error word, 1 = event byte, 2 = mask byte, 3 = control (enable in bit 0). Narrow registers are read zero-extended.

Top module: `bridge_irq_status`

## Requirements
- R1: After reset every register reads zero and `irq` is 0.
- R2: A pulse on `err_pulse[3]`, `[2]`, `[1]`, `[0]` sets error word bit 15 (parity), 14 (system error), 13 (master abort), 12 (target abort) in the next cycle. The flag stays set until cleared, and error word bits 11:0 always read 0.
- R3: A write to select 0 clears each error bit 15:12 whose `wr_data` bit is 1 and leaves bits written with 0 unchanged.
- R4: A pulse on `evt_pulse[i]` sets event bit i in the next cycle and the bit stays set. Bits from 7 down to 0 are mailbox, read abort, write abort, bus pin interrupt, parity error, inbound queue post, DMA channel 1, DMA channel 0.
- R5: A write to select 1 with `wr_data[7:0]` equal to 0 clears all event bits. A write with a nonzero value leaves the event byte unchanged.
- R6: When a pulse and a clearing write to the same register fall in one cycle, the pulsed bit ends up set.
- R7: A write to select 2 loads the mask from `wr_data[7:0]`. The mask reads back unchanged and uses the event bit positions.
- R8: A write to select 3 loads the global enable from `wr_data[0]`. While the enable is 0, `irq` is 0 in the following cycle.
- R9: `irq` is registered. In each cycle it equals the enable AND the OR over (event AND mask) as it stood in the previous cycle.
- R10: Error word flags have no effect on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 16 | Read data, zero-extended |
| err_pulse | input | 4 | Bus error pulses (parity, system, master abort, target abort from 3 to 0) |
| evt_pulse | input | 8 | Local event pulses, one per event bit |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle the assertions check three things. Pulses always land in their flags, even against a clearing write. Flags hold when nothing writes them, and a nonzero write leaves the event byte alone. The interrupt follows the enable, the event and the mask one cycle later. The bench's scenarios are needed for the rest: the exact bit placement of each error flag, the selective write-one-to-clear pattern, and the absence of any path from error flags to `irq`. A reference model in the bench compares the read port and `irq` on every clock during those scenarios.

// File: rtl/bis_pkg.sv
`timescale 1ns/1ps
package bis_pkg;
  typedef enum logic [1:0] {
    SEL_ERR  = 2'd0,
    SEL_EVT  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;
endpackage

// File: rtl/bis_rst_sync.sv
`timescale 1ns/1ps
module bis_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/bis_err_word.sv
`timescale 1ns/1ps
module bis_err_word #(
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_we,
  input  logic [ERR_W-1:0] clr_bits,
  input  logic [ERR_W-1:0] pulse,
  output logic [ERR_W-1:0] flags
);
  // one sticky write-one-to-clear cell per error bit
  for (genvar i = 0; i < ERR_W; i++) begin : g_cell
    logic flag_q, flag_d, flag_ce;

    always_comb begin
      flag_ce = pulse[i] | (clr_we & clr_bits[i]);
      flag_d  = pulse[i];   // pulse wins over a clear in the same cycle
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (flag_ce) flag_q <= flag_d;
    end

    assign flags[i] = flag_q;
  end
endmodule

// File: rtl/bis_evt_byte.sv
`timescale 1ns/1ps
module bis_evt_byte #(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [EVT_W-1:0] wr_val,
  input  logic [EVT_W-1:0] pulse,
  output logic [EVT_W-1:0] events
);
  logic [EVT_W-1:0] evt_q, evt_d;
  logic             evt_ce;
  logic             zero_wr;

  always_comb begin
    zero_wr = wr_hit & (wr_val == '0);
    evt_ce  = zero_wr | (|pulse);
    evt_d   = zero_wr ? pulse : (evt_q | pulse);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      evt_q <= '0;
    else if (evt_ce) evt_q <= evt_d;
  end

  assign events = evt_q;
endmodule

// File: rtl/bis_irq_gen.sv
`timescale 1ns/1ps
module bis_irq_gen #(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [EVT_W-1:0] events,
  input  logic [EVT_W-1:0] mask,
  output logic             irq
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = enable & (|(events & mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/bridge_irq_status.sv
`timescale 1ns/1ps
module bridge_irq_status #(
  parameter int DATA_W  = 16,
  parameter int ERR_W   = 4,
  parameter int EVT_W   = 8,
  parameter int SEL_W   = 2,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ERR_W-1:0]  err_pulse,
  input  logic [EVT_W-1:0]  evt_pulse,
  output logic              irq
);
  import bis_pkg::*;

  localparam int ERR_LSB = DATA_W - ERR_W;

  logic             rst_q_n;
  logic [ERR_W-1:0] err_q;
  logic [EVT_W-1:0] evt_q;
  logic [EVT_W-1:0] mask_q, mask_d;
  logic             en_q, en_d;
  logic             wr_err, wr_evt, wr_mask, wr_ctrl;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^wr_data[ERR_LSB-1:EVT_W];

  bis_rst_sync #(.STAGES(SYNC_ST)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  always_comb begin
    wr_err  = wr_en & (wr_sel == SEL_ERR);
    wr_evt  = wr_en & (wr_sel == SEL_EVT);
    wr_mask = wr_en & (wr_sel == SEL_MASK);
    wr_ctrl = wr_en & (wr_sel == SEL_CTRL);
    mask_d  = wr_data[EVT_W-1:0];
    en_d    = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     mask_q <= '0;
    else if (wr_mask) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     en_q <= 1'b0;
    else if (wr_ctrl) en_q <= en_d;
  end

  bis_err_word #(.ERR_W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_q_n), .clr_we(wr_err),
    .clr_bits(wr_data[DATA_W-1:ERR_LSB]), .pulse(err_pulse), .flags(err_q)
  );

  bis_evt_byte #(.EVT_W(EVT_W)) u_evt (
    .clk(clk), .rst_n(rst_q_n), .wr_hit(wr_evt),
    .wr_val(wr_data[EVT_W-1:0]), .pulse(evt_pulse), .events(evt_q)
  );

  bis_irq_gen #(.EVT_W(EVT_W)) u_irq (
    .clk(clk), .rst_n(rst_q_n), .enable(en_q),
    .events(evt_q), .mask(mask_q), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_ERR:  rd_data[DATA_W-1:ERR_LSB] = err_q;
      SEL_EVT:  rd_data[EVT_W-1:0]        = evt_q;
      SEL_MASK: rd_data[EVT_W-1:0]        = mask_q;
      default:  rd_data[0]                = en_q;
    endcase
  end
endmodule

// File: rtl/bis_checker.sv
`timescale 1ns/1ps
module bis_checker #(
  parameter int ERR_W = 4,
  parameter int EVT_W = 8,
  parameter int LOW_W = 12,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic [EVT_W-1:0] wr_low,
  input logic [SEL_W-1:0] rd_sel,
  input logic [LOW_W-1:0] rd_low,
  input logic [ERR_W-1:0] err_pulse,
  input logic [EVT_W-1:0] evt_pulse,
  input logic [ERR_W-1:0] err_q,
  input logic [EVT_W-1:0] evt_q,
  input logic [EVT_W-1:0] mask_q,
  input logic             en_q,
  input logic             irq
);
  assert_err_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|err_pulse) |=> ((err_q & $past(err_pulse)) == $past(err_pulse)));

  assert_err_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_sel == 2'd0) |-> (rd_low == '0));

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!(wr_en && wr_sel == 2'd0) && err_pulse == '0) |=> $stable(err_q));

  assert_evt_pulse_sets_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|evt_pulse) |=> ((evt_q & $past(evt_pulse)) == $past(evt_pulse)));

  assert_evt_nonzero_wr_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!(wr_en && wr_sel == 2'd1 && wr_low == '0) && evt_pulse == '0) |=> $stable(evt_q));

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!en_q) |=> !irq);

  assert_irq_rises_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en_q && (|(evt_q & mask_q))) |=> irq);

  assert_irq_falls_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!(|(evt_q & mask_q))) |=> !irq);
endmodule

bind bridge_irq_status bis_checker #(
  .ERR_W(ERR_W), .EVT_W(EVT_W), .LOW_W(ERR_LSB), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_low(wr_data[EVT_W-1:0]), .rd_sel(rd_sel), .rd_low(rd_data[ERR_LSB-1:0]),
  .err_pulse(err_pulse), .evt_pulse(evt_pulse), .err_q(err_q), .evt_q(evt_q),
  .mask_q(mask_q), .en_q(en_q), .irq(irq)
);

// File: tb/tb_bridge_irq_status.sv
`timescale 1ns/1ps
module tb_bridge_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [15:0] rd_data;
  logic [3:0]  err_pulse = 4'd0;
  logic [7:0]  evt_pulse = 8'd0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit model_on = 1'b0;

  // behavioural reference state
  logic [15:0] m_err = 16'd0;
  logic [7:0]  m_evt = 8'd0, m_mask = 8'd0;
  logic        m_en = 1'b0, m_irq = 1'b0;

  always #5 clk = ~clk;

  bridge_irq_status dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .err_pulse(err_pulse),
    .evt_pulse(evt_pulse), .irq(irq)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_err = 0; m_evt = 0; m_mask = 0; m_en = 0; m_irq = 0;
    end else begin
      m_irq = m_en && ((m_evt & m_mask) != 0);
      if (wr_en && wr_sel == 2'd0) m_err = m_err & ~(wr_data & 16'hF000);
      m_err = m_err | {err_pulse, 12'h000};
      if (wr_en && wr_sel == 2'd1 && wr_data[7:0] == 8'h00) m_evt = 8'h00;
      m_evt = m_evt | evt_pulse;
      if (wr_en && wr_sel == 2'd2) m_mask = wr_data[7:0];
      if (wr_en && wr_sel == 2'd3) m_en = wr_data[0];
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (model_on) begin
      check({15'd0, irq}, {15'd0, m_irq}, "R9 model irq");
      case (rd_sel)
        2'd0: check(rd_data, m_err, "R2/R3 model error word");
        2'd1: check(rd_data, {8'd0, m_evt}, "R4/R5 model event byte");
        2'd2: check(rd_data, {8'd0, m_mask}, "R7 model mask");
        default: check(rd_data, {15'd0, m_en}, "R8 model control");
      endcase
    end
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input logic we, input logic [1:0] sel, input logic [15:0] d,
                      input logic [3:0] ep, input logic [7:0] vp);
    @(negedge clk); #1;
    wr_en = we; wr_sel = sel; wr_data = d; err_pulse = ep; evt_pulse = vp;
  endtask

  task automatic peek(input logic [1:0] sel, input logic [15:0] exp, input string tag);
    @(negedge clk); #1;
    wr_en = 0; err_pulse = 0; evt_pulse = 0; rd_sel = sel;
    @(negedge clk);
    check(rd_data, exp, tag);
  endtask

  task automatic peek_irq(input logic exp, input string tag);
    @(negedge clk); #1;
    wr_en = 0; err_pulse = 0; evt_pulse = 0;
    @(negedge clk);
    check({15'd0, irq}, {15'd0, exp}, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1'b1;

    peek(2'd0, 16'h0000, "R1 error word after reset");
    peek(2'd1, 16'h0000, "R1 event byte after reset");
    peek(2'd2, 16'h0000, "R1 mask after reset");
    peek(2'd3, 16'h0000, "R1 control after reset");
    peek_irq(1'b0, "R1 irq after reset");

    step(0, 2'd0, 16'h0000, 4'b1010, 8'h00);
    peek(2'd0, 16'hA000, "R2 parity and master abort flags");
    step(0, 2'd0, 16'h0000, 4'b0001, 8'h00);
    peek(2'd0, 16'hB000, "R2 target abort flag sticky");
    step(1, 2'd0, 16'h2000, 4'b0000, 8'h00);
    peek(2'd0, 16'h9000, "R3 clear master abort only");
    step(1, 2'd0, 16'h0FFF, 4'b0000, 8'h00);
    peek(2'd0, 16'h9000, "R3 low bits write has no effect");
    step(1, 2'd0, 16'h8000, 4'b1000, 8'h00);
    peek(2'd0, 16'h9000, "R6 parity pulse beats clear");
    step(1, 2'd0, 16'hF000, 4'b0000, 8'h00);
    peek(2'd0, 16'h0000, "R3 clear all error flags");

    step(0, 2'd0, 16'h0000, 4'b0000, 8'h81);
    peek(2'd1, 16'h0081, "R4 mailbox and DMA0 events");
    peek_irq(1'b0, "R9 no irq with zero mask");
    step(1, 2'd1, 16'h0055, 4'b0000, 8'h00);
    peek(2'd1, 16'h0081, "R5 nonzero write ignored");
    step(1, 2'd1, 16'h0000, 4'b0000, 8'h00);
    peek(2'd1, 16'h0000, "R5 zero write clears events");

    step(1, 2'd2, 16'h000F, 4'b0000, 8'h00);
    peek(2'd2, 16'h000F, "R7 mask readback");
    step(0, 2'd0, 16'h0000, 4'b0000, 8'h04);
    peek_irq(1'b0, "R8 irq blocked by enable");
    step(1, 2'd3, 16'h0001, 4'b0000, 8'h00);
    peek_irq(1'b1, "R9 irq after enable");
    peek(2'd3, 16'h0001, "R8 control readback");
    step(1, 2'd1, 16'h0000, 4'b0000, 8'h00);
    peek_irq(1'b0, "R9 irq drops after event clear");
    step(0, 2'd0, 16'h0000, 4'b0000, 8'h80);
    peek_irq(1'b0, "R9 masked-out event gives no irq");
    step(1, 2'd1, 16'h0000, 4'b0000, 8'h00);
    step(1, 2'd2, 16'h00FF, 4'b0000, 8'h00);
    step(0, 2'd0, 16'h0000, 4'b1111, 8'h00);
    peek_irq(1'b0, "R10 error flags do not interrupt");
    peek(2'd0, 16'hF000, "R2 all error flags set");
    step(1, 2'd1, 16'h0000, 4'b0000, 8'h02);
    peek(2'd1, 16'h0002, "R6 event pulse beats zero write");
    peek_irq(1'b1, "R9 irq from DMA1 event");
    step(1, 2'd3, 16'h0000, 4'b0000, 8'h00);
    peek_irq(1'b0, "R8 irq off after disable");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule